// File: doc/BRIEF.md
# Write-Triggered Serial Shift Engine

This block moves one byte at a time between a parallel register and a serial line. Software loads the data register. If the interface is enabled, that write also starts a transfer. The engine then runs eight serial clock periods. On each falling clock edge it puts the most significant bit that has not yet been sent on the output pin. On each rising clock edge it shifts the sampled input bit in at the bottom of the register. After the eighth rising edge the register holds the byte that was received, and a one-cycle completion pulse is raised.

The engine has two pin arrangements:
- **Three-wire mode** uses a separate serial-in pin and serial-out pin.
- **Two-wire mode** uses one open-drain data line. The engine only ever pulls the line low. It reads the line back as its input. To receive, software preloads 0xFF so the line is left released.

The serial clock can come from either side:
- **Internal clock:** a divider generates the clock and drives it onto the clock pin.
- **External clock:** the clock is taken from the clock input pin. That pin is passed through a two-flop synchroniser, and its edges are detected in the system clock domain.

Between transfers, software can set the idle level of the data pin through a small output latch.

Top module: `sershift_engine`

## Requirements
- R1: A write (`wr_en`=1) while `ctl_enable`=1 and `busy`=0 loads `wr_data` into `rd_data` and sets `busy` in the following cycle.
- R2: A write while `ctl_enable`=0 only loads `rd_data`. `busy` stays 0, no `done` pulse appears and the serial clock stays high.
- R3: The transmitted bits appear most significant bit first. The first bit is valid from the start of the transfer, and each later bit changes only on a falling serial clock edge. In three-wire mode the bits appear on `sdo`.
- R4: Input bits are sampled on rising serial clock edges, first bit into the most significant position. After the transfer `rd_data` equals the received byte.
- R5: A transfer lasts exactly 8 rising clock edges. `done` is high for exactly one cycle, in the same cycle that `busy` returns to 0.
- R6: With `ctl_int_clk`=1, `sck_oe`=1 and `sck_out` idles high. Each half-period is HALF_DIV system cycles, so `done` rises 16*HALF_DIV cycles after `busy` rises.
- R7: With `ctl_int_clk`=0, `sck_oe`=0 and the engine shifts only on edges of `sck_in`, taken through a two-flop synchroniser.
- R8: In two-wire mode (`ctl_two_wire`=1), a transmitted 0 asserts `sda_oe` (pull low), a transmitted 1 releases the line, input is read from `sda_in`, and `sdo` stays 1. With 0xFF loaded, the line is never pulled low and `rd_data` ends equal to the byte driven by the other side.
- R9: In two-wire mode, when both sides drive, the byte received by each side is the bitwise AND of the two transmitted bytes.
- R10: While `busy`=0, `latch_wr` sets the data-pin idle level to `latch_val` on `sdo` (three-wire) or on the line through `sda_oe`=~`latch_val` (two-wire). While `busy`=1 it has no effect.
- R11: A write while `busy`=1 is ignored. The byte in flight is transmitted unchanged.
- R12: Clearing `ctl_enable` during a transfer aborts it. `busy` goes to 0 the next cycle, `sck_out` returns high and no `done` pulse follows.
- R13: After reset `busy`=0, `done`=0, `sck_out`=1, `sdo`=1 and `sda_oe`=0. `rd_data` is undefined until the first write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_enable | input | 1 | Interface enable; a write starts a transfer only when 1; clearing aborts |
| ctl_two_wire | input | 1 | 0: separate in/out pins; 1: shared open-drain data line |
| ctl_int_clk | input | 1 | 1: internal divider drives the clock pin; 0: external clock |
| wr_en | input | 1 | Data register write strobe |
| wr_data | input | DATA_W | Data register write value |
| rd_data | output | DATA_W | Data register contents |
| latch_wr | input | 1 | Output latch write strobe (idle only) |
| latch_val | input | 1 | Output latch value |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle transfer completion pulse |
| sck_in | input | 1 | External serial clock |
| sck_out | output | 1 | Generated serial clock, idle high |
| sck_oe | output | 1 | Clock pin output enable |
| sdi | input | 1 | Serial input, three-wire mode |
| sdo | output | 1 | Serial output, three-wire mode |
| sda_in | input | 1 | Shared data line level |
| sda_oe | output | 1 | Pull shared data line low when 1 |

## Verification
The assertions assume three things about the inputs:
- The mode and clock-source controls are not changed while `busy` is high.
- With an external clock, `sck_in` is high when a transfer starts, and each of its half-periods is longer than the synchroniser delay.
- With the internal clock, the other side changes its data no later than the falling clock edge, so the data is stable through the synchroniser before the rising edge.

The bench keeps within these assumptions:
- Controls change only while the engine is idle, apart from the deliberate enable-clear abort.
- Its external clock half-period is eight system cycles.
- Its model of the other side changes data only on falling clock edges and starts with the clock high.

// File: rtl/sershift_pkg.sv
// Package: shared types for the serial shift engine.
// Assumes: pin samples are grouped so one synchroniser instance serves all inputs.
package sershift_pkg;

    typedef enum logic {
        WIRE3 = 1'b0,   // separate serial-in and serial-out pins
        WIRE2 = 1'b1    // shared open-drain data line
    } wire_mode_e;

    typedef struct packed {
        logic sck;
        logic sdi;
        logic sda;
    } pin_sample_t;

    localparam int PIN_W = $bits(pin_sample_t);

endpackage

// File: rtl/sershift_sync.sv
// Module: multi-stage synchroniser for asynchronous pin inputs.
// Assumes: each bit is independent; the reset value matches the idle pin level.
module sershift_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        // Shift the pin value one flop further along the chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[g] <= RST_VAL;
            end else begin
                stage_q[g] <= (g == 0) ? d_in : stage_q[(g == 0) ? 0 : g - 1];
            end
        end
    end

    assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/sershift_clkgen.sv
// Module: internal serial clock generator.
// Assumes: run is held for the whole transfer; the clock idles high and the
// first edge after run rises is a falling edge, HALF_DIV cycles later.
module sershift_clkgen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sck,
    output logic fall_ev,
    output logic rise_ev
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] div_q;
    logic          sck_q;
    logic          term;

    assign term = (div_q == CW'(HALF_DIV - 1));

    // Count out each half-period and toggle the clock level at its end.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_q <= '0;
            sck_q <= 1'b1;
        end else if (term) begin
            div_q <= '0;
            sck_q <= ~sck_q;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    // Edge strobes mark the cycle whose clock edge moves the level.
    assign fall_ev = run && term && sck_q;
    assign rise_ev = run && term && !sck_q;
    assign sck     = sck_q;
endmodule

// File: rtl/sershift_bitcnt.sv
// Module: bit counter that flags the last of COUNT rising edges.
// Assumes: clear and step are never high in the same cycle.
module sershift_bitcnt #(
    parameter int COUNT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    output logic last
);
    localparam int CW = (COUNT > 1) ? $clog2(COUNT) : 1;

    logic [CW-1:0] cnt_q;

    assign last = step && (cnt_q == CW'(COUNT - 1));

    // Advance on each sampled bit; restart at zero on a new transfer.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= last ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/sershift_engine.sv
// Module: write-triggered serial shift engine (top).
// Assumes: mode and clock-source controls are stable while busy; an external
// clock idles high and has half-periods longer than the synchroniser delay.
module sershift_engine
    import sershift_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int HALF_DIV    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_enable,
    input  logic              ctl_two_wire,
    input  logic              ctl_int_clk,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              latch_wr,
    input  logic              latch_val,
    output logic              busy,
    output logic              done,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              sdi,
    output logic              sdo,
    input  logic              sda_in,
    output logic              sda_oe
);
    localparam int MSB = DATA_W - 1;

    pin_sample_t pin_raw, pin_s;
    wire_mode_e  mode;
    logic [MSB:0] sr_q;
    logic busy_q, done_q, dout_q, sck_prev_q;
    logic start, run_int, din;
    logic int_sck, int_fall, int_rise;
    logic ext_fall, ext_rise;
    logic fall_ev, rise_ev, last_bit;

    assign mode  = wire_mode_e'(ctl_two_wire);
    assign start = wr_en && ctl_enable && !busy_q;

    // Bring the asynchronous pins into the system clock domain.
    assign pin_raw = '{sck: sck_in, sdi: sdi, sda: sda_in};
    sershift_sync #(
        .W      (PIN_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL('1)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in (pin_raw),
        .d_out(pin_s)
    );

    // Internal clock runs only while an enabled transfer is in flight.
    assign run_int = busy_q && ctl_enable && ctl_int_clk;
    sershift_clkgen #(
        .HALF_DIV(HALF_DIV)
    ) u_clkgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run_int),
        .sck    (int_sck),
        .fall_ev(int_fall),
        .rise_ev(int_rise)
    );

    // Remember the last synchronised external clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_prev_q <= 1'b1;
        end else begin
            sck_prev_q <= pin_s.sck;
        end
    end

    assign ext_fall = busy_q && ctl_enable && sck_prev_q && !pin_s.sck;
    assign ext_rise = busy_q && ctl_enable && !sck_prev_q && pin_s.sck;

    assign fall_ev = ctl_int_clk ? int_fall : ext_fall;
    assign rise_ev = ctl_int_clk ? int_rise : ext_rise;

    sershift_bitcnt #(
        .COUNT(DATA_W)
    ) u_bitcnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(start),
        .step (rise_ev),
        .last (last_bit)
    );

    // Select the serial input source for the active pin arrangement.
    assign din = (mode == WIRE2) ? pin_s.sda : pin_s.sdi;

    // Data register: loaded by an idle write, shifted on each rising edge.
    always_ff @(posedge clk) begin
        if (wr_en && !busy_q) begin
            sr_q <= wr_data;
        end else if (rise_ev) begin
            sr_q <= {sr_q[MSB-1:0], din};
        end
    end

    // Transfer state: start on an enabled write, end on the last bit or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= rise_ev && last_bit;
            if (!ctl_enable) begin
                busy_q <= 1'b0;
            end else if (start) begin
                busy_q <= 1'b1;
            end else if (rise_ev && last_bit) begin
                busy_q <= 1'b0;
            end
        end
    end

    // Output latch: first bit at start, next bit on falls, software when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout_q <= 1'b1;
        end else if (start) begin
            dout_q <= wr_data[MSB];
        end else if (fall_ev) begin
            dout_q <= sr_q[MSB];
        end else if (!busy_q && latch_wr) begin
            dout_q <= latch_val;
        end
    end

    // Pin drive for the selected arrangement and clock direction.
    assign sdo     = (mode == WIRE2) ? 1'b1 : dout_q;
    assign sda_oe  = (mode == WIRE2) && !dout_q;
    assign sck_out = ctl_int_clk ? int_sck : 1'b1;
    assign sck_oe  = ctl_int_clk;
    assign rd_data = sr_q;
    assign busy    = busy_q;
    assign done    = done_q;
endmodule

// File: rtl/sershift_engine_chk.sv
// Module: property checker for the serial shift engine, bound to the top.
// Assumes: inputs follow the rules listed in the brief's verification section.
module sershift_engine_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ctl_enable,
    input logic              ctl_two_wire,
    input logic              wr_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              busy,
    input logic              done,
    input logic              sck_out,
    input logic              sdo,
    input logic              sda_oe
);
    // R1: an enabled idle write starts a transfer next cycle.
    assert_start_on_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ctl_enable && !busy) |=> busy);

    // R2: with the interface disabled the engine never becomes busy.
    assert_disabled_stays_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_enable |=> !busy);

    // R2: idle register holds its value when nothing writes it.
    assert_idle_register_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy) && !$past(wr_en)) |-> $stable(rd_data));

    // R3: the first bit on the pin is the register's top bit when busy rises.
    assert_msb_presented_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ((ctl_two_wire ? !sda_oe : sdo) == rd_data[DATA_W-1]));

    // R5: completion is a single-cycle pulse.
    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5: completion coincides with busy dropping.
    assert_done_ends_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R6: the generated clock rests high whenever no transfer runs.
    assert_clock_idle_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> sck_out);

    // R12: clearing enable mid-transfer aborts with no completion.
    assert_abort_no_done_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ctl_enable) |=> (!busy && !done));
endmodule

bind sershift_engine sershift_engine_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_enable  (ctl_enable),
    .ctl_two_wire(ctl_two_wire),
    .wr_en       (wr_en),
    .rd_data     (rd_data),
    .busy        (busy),
    .done        (done),
    .sck_out     (sck_out),
    .sdo         (sdo),
    .sda_oe      (sda_oe)
);

// File: tb/sershift_engine_test.sv
module sershift_engine_test;
    localparam int HALF  = 4;
    localparam int EXT_H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_enable = 1'b0, ctl_two_wire = 1'b0, ctl_int_clk = 1'b1;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic latch_wr = 1'b0, latch_val = 1'b1;
    logic busy, done, sck_out, sck_oe, sdo, sda_oe;
    logic ext_sck = 1'b1;
    logic sdi, sda_in;

    // Model of the other side of the link.
    logic [7:0] rem_tx = 8'hFF;
    logic [7:0] rem_rx = 8'h00;
    int rem_falls = 0, rem_rises = 0;
    logic sck_line;

    int checks = 0, errors = 0;
    int cyc = 0, done_cnt = 0, done_cyc = 0;

    always #2.5 clk = ~clk;

    assign sck_line = ctl_int_clk ? sck_out : ext_sck;
    assign sdi      = rem_tx[7];
    assign sda_in   = !sda_oe && (ctl_two_wire ? rem_tx[7] : 1'b1);

    sershift_engine #(.DATA_W(8), .HALF_DIV(HALF), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable),
        .ctl_two_wire(ctl_two_wire), .ctl_int_clk(ctl_int_clk),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .latch_wr(latch_wr), .latch_val(latch_val),
        .busy(busy), .done(done),
        .sck_in(ext_sck), .sck_out(sck_out), .sck_oe(sck_oe),
        .sdi(sdi), .sdo(sdo), .sda_in(sda_in), .sda_oe(sda_oe)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) if (done) begin
        done_cnt = done_cnt + 1;
        done_cyc = cyc;
    end

    // Remote presents its next bit on every falling edge after the first.
    always @(negedge sck_line) begin
        if (rem_falls != 0) rem_tx = {rem_tx[6:0], 1'b1};
        rem_falls = rem_falls + 1;
    end

    // Remote samples the line on every rising edge.
    always @(posedge sck_line) begin
        rem_rx = {rem_rx[6:0], (ctl_two_wire ? sda_in : sdo)};
        rem_rises = rem_rises + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        checks = checks + 1;
        errors = errors + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    task automatic arm_remote(input logic [7:0] b);
        rem_tx = b;
        rem_rx = 8'h00;
        rem_falls = 0;
        rem_rises = 0;
        done_cnt = 0;
    endtask

    task automatic write_reg(input logic [7:0] d);
        wr_data = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ext_clock_byte();
        for (int i = 0; i < 8; i++) begin
            ext_sck = 1'b0;
            repeat (EXT_H) @(negedge clk);
            ext_sck = 1'b1;
            repeat (EXT_H) @(negedge clk);
        end
        repeat (6) @(negedge clk);
    endtask

    task automatic wait_done();
        for (int i = 0; i < 400 && done_cnt == 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // One full transfer with the remote model; expected values from the rules.
    task automatic xfer(input logic [7:0] a, input logic [7:0] b, input logic two, input logic intc);
        logic [7:0] exp_rd, exp_rem;
        int t0;
        ctl_two_wire = two;
        ctl_int_clk = intc;
        @(negedge clk);
        arm_remote(b);
        write_reg(a);
        t0 = cyc;
        chk("R1", busy, 1, "busy after enabled write");
        chk(intc ? "R6" : "R7", sck_oe, intc, "clock pin direction");
        if (intc) wait_done(); else ext_clock_byte();
        exp_rd  = two ? (a & b) : b;
        exp_rem = two ? (a & b) : a;
        chk(two ? "R9" : "R4", rd_data, exp_rd, "received byte");
        chk(two ? "R8" : "R3", rem_rx, exp_rem, "byte seen by remote");
        chk("R5", done_cnt, 1, "done pulse count");
        chk("R5", rem_rises, 8, "rising edges per byte");
        chk("R5", busy, 0, "busy after byte");
        if (intc) chk("R6", done_cyc - t0, 16 * HALF, "cycles start to done");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R13", busy, 0, "busy in reset");
        chk("R13", done, 0, "done in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk("R13", sck_out, 1, "clock level after reset");
        chk("R13", sdo, 1, "sdo after reset");
        chk("R13", sda_oe, 0, "sda_oe after reset");

        // R2: disabled write only loads.
        arm_remote(8'hFF);
        write_reg(8'h5A);
        chk("R2", busy, 0, "busy after disabled write");
        chk("R2", rd_data, 8'h5A, "register after disabled write");
        repeat (40) @(negedge clk);
        chk("R2", busy, 0, "still idle");
        chk("R2", done_cnt, 0, "no done when disabled");
        chk("R2", sck_out, 1, "clock held high");

        ctl_enable = 1'b1;

        // R10: software latch sets the idle pin level.
        ctl_two_wire = 1'b0;
        latch_val = 1'b0; latch_wr = 1'b1; @(negedge clk); latch_wr = 1'b0;
        chk("R10", sdo, 0, "three-wire latch low");
        latch_val = 1'b1; latch_wr = 1'b1; @(negedge clk); latch_wr = 1'b0;
        chk("R10", sdo, 1, "three-wire latch high");
        ctl_two_wire = 1'b1;
        latch_val = 1'b0; latch_wr = 1'b1; @(negedge clk); latch_wr = 1'b0;
        chk("R10", sda_oe, 1, "two-wire latch pulls low");
        chk("R8", sdo, 1, "sdo held high in two-wire");
        latch_val = 1'b1; latch_wr = 1'b1; @(negedge clk); latch_wr = 1'b0;
        chk("R10", sda_oe, 0, "two-wire latch releases");

        // R3/R4: three-wire internal clock, every transmit value.
        for (int a = 0; a < 256; a++)
            xfer(8'(a), 8'((a * 73 + 29) & 255), 1'b0, 1'b1);

        // R7: three-wire external clock.
        for (int a = 0; a < 256; a += 3)
            xfer(8'(a), ~8'(a), 1'b0, 1'b0);

        // R8: two-wire receive with 0xFF preloaded, every remote byte.
        for (int b = 0; b < 256; b++)
            xfer(8'hFF, 8'(b), 1'b1, 1'b1);

        // R9: two-wire wired-AND with both sides driving, external clock.
        for (int a = 0; a < 256; a += 3)
            xfer(8'(a), 8'((a * 5 + 3) & 255), 1'b1, 1'b0);

        // R11 and R10: writes and latch writes during a transfer are ignored.
        ctl_two_wire = 1'b0; ctl_int_clk = 1'b1;
        @(negedge clk);
        arm_remote(8'h3C);
        write_reg(8'hA5);
        repeat (10) @(negedge clk);
        write_reg(8'h00);
        latch_val = 1'b0; latch_wr = 1'b1; @(negedge clk); latch_wr = 1'b0;
        wait_done();
        chk("R11", rem_rx, 8'hA5, "byte sent despite busy write");
        chk("R11", rd_data, 8'h3C, "received despite busy write");
        chk("R10", done_cnt, 1, "latch write while busy harmless");

        // R12: abort by clearing enable.
        arm_remote(8'hFF);
        write_reg(8'h81);
        repeat (20) @(negedge clk);
        ctl_enable = 1'b0;
        @(negedge clk);
        chk("R12", busy, 0, "busy after abort");
        chk("R12", sck_out, 1, "clock high after abort");
        repeat (60) @(negedge clk);
        chk("R12", done_cnt, 0, "no done after abort");

        summary();
    end
endmodule